// File: doc/BRIEF.md
# Read-Priority Write-Drain Request Scheduler

This block sits in front of the bank array of a phase-change main memory with one rank and eight banks. It accepts one read or write request per cycle and holds writes in an age-ordered write queue and reads in a small read FIFO. Each cycle it offers at most one bank command to the power token manager and the bank timing logic. A command is valid for the cycle in which `cmd_valid` is high and is consumed at the next rising clock edge.

Reads take precedence. Writes drain in idle cycles with no read waiting. When the write queue fills, the scheduler switches to a drain mode and holds back reads until every queued write has gone out. The power manager reports, for each bank, whether a write to that bank fits the present power budget. A write whose bank is busy or over budget is passed over in favour of the oldest younger write that can proceed. A read whose address matches a queued write is answered from the queue and never goes to the array.

Top module: `rws_top`

## Requirements
- R1: After reset the write queue is empty, not full, drain mode is off, no command is offered, and `req_ready` is high.
- R2: The bank of any address is its three low bits, and `cmd_bank` always equals the three low bits of `cmd_addr`. Reads leave in arrival order.
- R3: Outside drain mode, a write is offered only when the read FIFO is empty, so a waiting read goes out first.
- R4: The write offered is the oldest queued write whose bank is idle and whose power grant is high. A write to a busy bank is bypassed by a younger one to an idle bank.
- R5: When the oldest write is refused power, a younger write to a bank with a grant is offered ahead of it.
- R6: A write is never offered to a bank with `bank_busy` high or `wr_pwr_ok` low.
- R7: Drain mode turns on in the same cycle the write queue holds its full depth (24). While drain mode is on, writes issue back to back and no read is offered.
- R8: Drain mode stays on until the write queue is empty and turns off in the cycle it becomes empty.
- R9: A read to an address with a queued write returns the youngest matching write data on `rd_fwd_data` with `rd_fwd_valid` high one cycle after acceptance. That read is not queued and is never offered as a command.
- R10: Writes to the same address are offered in the order they arrived.
- R11: `wq_full` and `wq_empty` reflect the write-queue occupancy. `req_ready` is low while either queue is full, and a request presented then is dropped.
- R12: A read whose bank is busy waits at the FIFO head, and outside drain mode no write is offered meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Request address, bank in bits 2:0 |
| req_data | input | 8 | Write data |
| req_ready | output | 1 | Both queues have room |
| bank_busy | input | 8 | One bit per bank, 1 = busy |
| wr_pwr_ok | input | 8 | One bit per bank, 1 = a write fits the power budget |
| cmd_valid | output | 1 | Command offered this cycle |
| cmd_wr | output | 1 | Offered command is a write |
| cmd_bank | output | 3 | Bank of the offered command |
| cmd_addr | output | 8 | Address of the offered command |
| cmd_data | output | 8 | Write data of the offered command, zero for reads |
| rd_fwd_valid | output | 1 | Read answered from the write queue |
| rd_fwd_data | output | 8 | Forwarded read data |
| wq_full | output | 1 | Write queue holds 24 entries |
| wq_empty | output | 1 | Write queue holds no entry |
| burst_mode | output | 1 | Drain mode active |

## Verification
The assertions assume that the downstream logic takes every offered command at the next edge. They also assume that the busy and power-grant vectors are stable through the cycle in which a write is chosen. The bench changes `bank_busy` and `wr_pwr_ok` only just after a falling edge, and it samples the offer before the next rising edge. Requests are driven with `req_ready` high, except for one deliberate attempt on a full queue, which the design must drop.

// File: rtl/rws_pkg.sv
package rws_pkg;
  parameter int unsigned ADDR_W   = 8;
  parameter int unsigned DATA_W   = 8;
  parameter int unsigned NBANK    = 8;
  parameter int unsigned WQ_DEPTH = 24;
  parameter int unsigned RQ_DEPTH = 8;
  localparam int unsigned BANK_W  = $clog2(NBANK);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [BANK_W-1:0] bank_t;

  typedef struct packed {
    addr_t addr;
    data_t data;
  } wr_ent_t;

  // bank select lives in the low address bits
  function automatic bank_t bank_of(input addr_t a);
    return a[BANK_W-1:0];
  endfunction
endpackage

// File: rtl/rws_wr_queue.sv
module rws_wr_queue
  import rws_pkg::*;
#(
  parameter int unsigned DEPTH = WQ_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  wr_ent_t          push_ent,
  input  logic             pop,
  input  logic [NBANK-1:0] bank_busy,
  input  logic [NBANK-1:0] pwr_ok,
  input  addr_t            look_addr,
  output logic [CNT_W-1:0] count,
  output logic             pick_valid,
  output wr_ent_t          pick_ent,
  output logic             look_hit,
  output data_t            look_data
);
  wr_ent_t          mem [DEPTH];
  wr_ent_t          nxt [DEPTH];
  logic [IDX_W-1:0] pick_idx;
  logic [CNT_W-1:0] cnt_after;
  logic [CNT_W-1:0] cnt_nxt;

  // oldest eligible entry: scan from youngest so the lowest index wins
  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (CNT_W'(i) < count && !bank_busy[bank_of(mem[i].addr)]
          && pwr_ok[bank_of(mem[i].addr)]) begin
        pick_valid = 1'b1;
        pick_idx   = IDX_W'(i);
      end
    end
    pick_ent = mem[pick_idx];
  end

  // youngest matching entry supplies forwarded read data
  always_comb begin
    look_hit  = 1'b0;
    look_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < count && mem[i].addr == look_addr) begin
        look_hit  = 1'b1;
        look_data = mem[i].data;
      end
    end
  end

  // remove the picked slot by closing the gap, then append at the tail
  always_comb begin
    for (int i = 0; i < DEPTH; i++) nxt[i] = mem[i];
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++)
        if (IDX_W'(i) >= pick_idx) nxt[i] = mem[i+1];
    end
    cnt_after = count - CNT_W'(pop);
    if (push) nxt[IDX_W'(cnt_after)] = push_ent;
    cnt_nxt = cnt_after + CNT_W'(push);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_nxt;
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CNT_W'(DEPTH) || pop));

  assert_pop_has_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> pick_valid);

  assert_pop_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/rws_rd_fifo.sv
module rws_rd_fifo
  import rws_pkg::*;
#(
  parameter int unsigned DEPTH = RQ_DEPTH,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  addr_t push_addr,
  input  logic  pop,
  output addr_t head,
  output logic  empty,
  output logic  full
);
  addr_t            mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assert_rd_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_rd_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rws_top.sv
module rws_top
  import rws_pkg::*;
#(
  parameter int unsigned WQ_N = WQ_DEPTH,
  parameter int unsigned RQ_N = RQ_DEPTH,
  localparam int unsigned WCNT_W = $clog2(WQ_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  input  logic [NBANK-1:0]  bank_busy,
  input  logic [NBANK-1:0]  wr_pwr_ok,
  output logic              cmd_valid,
  output logic              cmd_wr,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              rd_fwd_valid,
  output logic [DATA_W-1:0] rd_fwd_data,
  output logic              wq_full,
  output logic              wq_empty,
  output logic              burst_mode
);
  // named internal events
  logic              accept, wr_push, rd_push, rd_hit;
  logic              rd_go, wr_go;
  logic              rq_empty, rq_full;
  addr_t             rq_head;
  logic [WCNT_W-1:0] wq_count, wq_count_nxt;
  logic              pick_valid;
  wr_ent_t           pick_ent;
  data_t             hit_data;
  logic              burst_q, burst_nxt;

  assign req_ready = !wq_full && !rq_full;
  assign accept    = req_valid && req_ready;
  assign wr_push   = accept && req_wr;
  assign rd_push   = accept && !req_wr && !rd_hit;

  rws_wr_queue #(.DEPTH(WQ_N)) u_wq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_push),
    .push_ent  ('{addr: req_addr, data: req_data}),
    .pop       (wr_go),
    .bank_busy (bank_busy),
    .pwr_ok    (wr_pwr_ok),
    .look_addr (req_addr),
    .count     (wq_count),
    .pick_valid(pick_valid),
    .pick_ent  (pick_ent),
    .look_hit  (rd_hit),
    .look_data (hit_data)
  );

  rws_rd_fifo #(.DEPTH(RQ_N)) u_rq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (rd_push),
    .push_addr(req_addr),
    .pop      (rd_go),
    .head     (rq_head),
    .empty    (rq_empty),
    .full     (rq_full)
  );

  assign wq_full  = (wq_count == WCNT_W'(WQ_N));
  assign wq_empty = (wq_count == '0);

  // reads first outside drain mode; writes only on an empty read FIFO or in drain
  assign rd_go = !burst_q && !rq_empty && !bank_busy[bank_of(rq_head)];
  assign wr_go = pick_valid && (burst_q || rq_empty);

  assign cmd_valid = rd_go || wr_go;
  assign cmd_wr    = wr_go;
  assign cmd_addr  = wr_go ? pick_ent.addr : rq_head;
  assign cmd_data  = wr_go ? pick_ent.data : '0;
  assign cmd_bank  = bank_of(cmd_addr);

  assign wq_count_nxt = wq_count + WCNT_W'(wr_push) - WCNT_W'(wr_go);
  assign burst_nxt    = burst_q ? (wq_count_nxt != '0)
                                : (wq_count_nxt == WCNT_W'(WQ_N));
  assign burst_mode   = burst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_q      <= 1'b0;
      rd_fwd_valid <= 1'b0;
      rd_fwd_data  <= '0;
    end else begin
      burst_q      <= burst_nxt;
      rd_fwd_valid <= accept && !req_wr && rd_hit;
      rd_fwd_data  <= hit_data;
    end
  end

  assert_wr_bank_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_wr) |-> (!bank_busy[cmd_bank] && wr_pwr_ok[cmd_bank]));

  assert_rd_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_wr && !burst_mode) |-> rq_empty);

  assert_full_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wq_full |-> burst_mode);

  assert_drain_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_mode |-> !(cmd_valid && !cmd_wr));

  assert_drain_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && wq_count > 1) |=> burst_mode);

  assert_empty_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wq_empty |-> !(cmd_valid && cmd_wr));

  assert_bank_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_bank == cmd_addr[BANK_W-1:0]);
endmodule

// File: tb/rws_top_tb.sv
module rws_top_tb;
  import rws_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_wr = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic              req_ready;
  logic [NBANK-1:0]  bank_busy = '1, wr_pwr_ok = '1;
  logic              cmd_valid, cmd_wr;
  logic [BANK_W-1:0] cmd_bank;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              rd_fwd_valid;
  logic [DATA_W-1:0] rd_fwd_data;
  logic              wq_full, wq_empty, burst_mode;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rws_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
    .bank_busy(bank_busy), .wr_pwr_ok(wr_pwr_ok), .cmd_valid(cmd_valid),
    .cmd_wr(cmd_wr), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_fwd_valid(rd_fwd_valid), .rd_fwd_data(rd_fwd_data),
    .wq_full(wq_full), .wq_empty(wq_empty), .burst_mode(burst_mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // packs {valid, wr, bank, addr, data}; bank expected as addr[2:0]
  task automatic chk_cmd(input string tag, input bit v, input bit w,
                         input logic [7:0] a, input logic [7:0] d);
    int act, exp;
    act = {cmd_valid, cmd_wr, cmd_bank, cmd_addr, cmd_data};
    exp = {v, w, a[2:0], a, d};
    if (!v) begin
      act = int'(cmd_valid);
      exp = 0;
    end
    chk(act == exp, tag, act, exp);
  endtask

  task automatic send(input bit wr, input logic [7:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk({wq_empty, wq_full, burst_mode, cmd_valid, req_ready} == 5'b10001,
        "R1 reset flags", {wq_empty, wq_full, burst_mode, cmd_valid, req_ready}, 5'b10001);
    @(negedge clk);

    // read priority, arrival order, bank field (all banks busy while loading)
    send(1, 8'h10, 8'h01);
    send(1, 8'h21, 8'h02);
    send(0, 8'h33, 8'h00);
    #1;
    chk(rd_fwd_valid == 1'b0, "R9 no forward on miss", rd_fwd_valid, 0);
    chk(wq_empty == 1'b0, "R11 not empty", wq_empty, 0);
    bank_busy = '0;
    #1;
    chk_cmd("R3 read first", 1, 0, 8'h33, 8'h00);
    tick(); chk_cmd("R4 oldest write", 1, 1, 8'h10, 8'h01);
    tick(); chk_cmd("R2 next write", 1, 1, 8'h21, 8'h02);
    tick(); chk_cmd("R11 idle when empty", 0, 0, 0, 0);
    chk(wq_empty == 1'b1, "R11 empty again", wq_empty, 1);

    // R12 read stuck on busy bank blocks writes outside drain mode
    bank_busy = 8'b0000_1000;
    send(0, 8'h33, 8'h00);
    send(1, 8'h44, 8'h0C);
    #1;
    chk_cmd("R12 blocked read holds writes", 0, 0, 0, 0);
    bank_busy = '0;
    #1;
    chk_cmd("R12 read leaves", 1, 0, 8'h33, 8'h00);
    tick(); chk_cmd("R3 write after read", 1, 1, 8'h44, 8'h0C);
    @(negedge clk);

    // R5 power refusal reorder
    bank_busy = '1;
    send(1, 8'h10, 8'h11);
    send(1, 8'h21, 8'h22);
    wr_pwr_ok = 8'b1111_1110;
    bank_busy = '0;
    #1;
    chk_cmd("R5 younger write bypasses", 1, 1, 8'h21, 8'h22);
    tick(); chk_cmd("R6 no write without power", 0, 0, 0, 0);
    wr_pwr_ok = '1;
    #1;
    chk_cmd("R6 write after grant", 1, 1, 8'h10, 8'h11);
    @(negedge clk);

    // R4 busy-bank reorder
    bank_busy = '1;
    send(1, 8'h10, 8'h31);
    send(1, 8'h22, 8'h32);
    bank_busy = 8'b0000_0001;
    #1;
    chk_cmd("R4 bypass busy bank", 1, 1, 8'h22, 8'h32);
    tick(); chk_cmd("R6 busy bank waits", 0, 0, 0, 0);
    bank_busy = '0;
    #1;
    chk_cmd("R4 then older write", 1, 1, 8'h10, 8'h31);
    @(negedge clk);

    // R9 forwarding and R10 same-address order
    bank_busy = '1;
    send(1, 8'h55, 8'hA1);
    send(1, 8'h55, 8'hA2);
    send(0, 8'h55, 8'h00);
    #1;
    chk({rd_fwd_valid, rd_fwd_data} == {1'b1, 8'hA2}, "R9 forward youngest",
        {rd_fwd_valid, rd_fwd_data}, {1'b1, 8'hA2});
    bank_busy = '0;
    #1;
    chk_cmd("R10 first same-addr write", 1, 1, 8'h55, 8'hA1);
    tick(); chk_cmd("R10 second same-addr write", 1, 1, 8'h55, 8'hA2);
    tick(); chk_cmd("R9 forwarded read never issued", 0, 0, 0, 0);
    @(negedge clk);

    // R7 / R8 drain mode
    bank_busy = '1;
    for (int k = 0; k < 24; k++) begin
      send(1, 8'h80 + 8'(k), 8'(k));
      if (k == 22) begin
        #1;
        chk({wq_full, burst_mode} == 2'b00, "R7 not yet full",
            {wq_full, burst_mode}, 0);
      end
    end
    #1;
    chk({wq_full, burst_mode, req_ready} == 3'b110, "R7 full enters drain",
        {wq_full, burst_mode, req_ready}, 3'b110);
    send(1, 8'h99, 8'hEE);
    #1;
    chk(wq_full == 1'b1, "R11 push on full dropped", wq_full, 1);
    bank_busy = '0;
    for (int k = 0; k < 24; k++) begin
      #1;
      chk(cmd_valid && cmd_wr && cmd_addr == 8'h80 + 8'(k) && cmd_data == 8'(k)
          && burst_mode, "R7 drain back to back", {burst_mode, cmd_addr},
          {1'b1, 8'h80 + 8'(k)});
      if (k == 1) begin
        req_valid = 1'b1; req_wr = 1'b0; req_addr = 8'h07;
      end
      if (k == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    #1;
    chk({wq_empty, burst_mode} == 2'b10, "R8 drain ends at empty",
        {wq_empty, burst_mode}, 2'b10);
    chk_cmd("R8 held read goes after drain", 1, 0, 8'h07, 8'h00);
    tick(); chk_cmd("R11 dropped write absent", 0, 0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule